// File: doc/BRIEF.md
# Synchronous Read Port with Soft Enable and Reset

This block puts a small synchronous RAM behind a read path that adds read enable, asynchronous reset and synchronous reset in plain logic. The RAM's own read port has no such controls: its read strobe is tied high, so it samples the addressed word on every clock edge. A one-bit select flop remembers whether the last edge was an enabled read. A hold register keeps a copy of the value last shown on the output. An output multiplexer picks fresh RAM data when the select is set and the held copy otherwise.

Both resets clear the select and load the hold register with a reset constant, one constant for each reset. A parameter picks how a synchronous reset that arrives with the enable low is treated. In reset-first mode the reset applies whatever the enable is. In enable-first mode the reset is qualified by the enable, and an idle port keeps its data. The write port is synchronous, on the same edge as the read, and a read of the word being written returns the old contents.

Top module: `sync_rd_shell`

## Requirements
- R1: While rst_ni is low, and after it is released, rd_data_o shows ARST_VAL (default 8'hA5) until the first enabled read or synchronous reset.
- R2: An edge with rd_en_i=1 and no active synchronous reset makes rd_data_o, from that edge on, equal the word stored at rd_addr_i before that edge.
- R3: An edge with rd_en_i=0 and no active synchronous reset leaves rd_data_o unchanged, even if the addressed word or rd_addr_i changes.
- R4: An edge with wr_en_i=1 stores wr_data_i at wr_addr_i, and a later enabled read of that address returns it.
- R5: When the read and write addresses match on the same edge, the read returns the contents before the write.
- R6: With PRIO=PRIO_SRST (the default), an edge with srst_i=1 sets rd_data_o to SRST_VAL (default 8'h3C), whatever rd_en_i is.
- R7: With PRIO=PRIO_EN, an edge with srst_i=1 sets rd_data_o to SRST_VAL only when rd_en_i=1. With rd_en_i=0 the output holds.
- R8: Pulling rst_ni low forces rd_data_o to ARST_VAL at once, without a clock edge, and it holds there while rst_ni stays low, even with rd_en_i and srst_i high.
- R9: After either reset, rd_data_o stays at the reset value through edges that have rd_en_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous reset of the read output |
| rd_en_i | input | 1 | Read enable |
| rd_addr_i | input | ADDR_W | Read address |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data as seen by the user |

## Verification
The sensitive collision is between the read enable and the synchronous reset on the same edge, because the two priority modes resolve it differently. The bench drives two instances, one in each mode, from the same stimulus. Directed edges apply reset with the enable low and with it high. Random traffic then sets the two controls together often. Each output is compared with a bench model of its own mode, so a reset that leaks through an idle enable-first port, or that an idle reset-first port ignores, is seen on the next edge.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
  typedef enum logic {
    PRIO_SRST = 1'b0,  // sync reset acts whatever the enable
    PRIO_EN   = 1'b1   // sync reset acts only with enable high
  } prio_e;
endpackage

// File: rtl/rdw_ram.sv
module rdw_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] q_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  // read takes the pre-write contents
  always_ff @(posedge clk_i) begin
    if (rd_en_i) q_o <= mem[rd_addr_i];
  end

  p_rd_old_r5: assert property (@(posedge clk_i)
    rd_en_i |=> q_o == $past(mem[rd_addr_i]));

  p_wr_store_r4: assert property (@(posedge clk_i)
    wr_en_i |=> mem[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/rdw_ctl.sv
module rdw_ctl
  import rdw_pkg::*;
#(
  parameter prio_e PRIO = PRIO_SRST
) (
  input  logic rd_en_i,
  input  logic srst_i,
  output logic en_eff_o,
  output logic srst_eff_o
);
  generate
    if (PRIO == PRIO_EN) begin : g_en_first
      // reset qualified by enable
      assign srst_eff_o = srst_i & rd_en_i;
      assign en_eff_o   = rd_en_i;
    end else begin : g_srst_first
      // enable widened so reset always reaches the flops
      assign srst_eff_o = srst_i;
      assign en_eff_o   = rd_en_i | srst_i;
    end
  endgenerate
endmodule

// File: rtl/rdw_hold.sv
module rdw_hold #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] ARST_VAL = 8'hA5,
  parameter logic [DATA_W-1:0] SRST_VAL = 8'h3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_eff_i,
  input  logic              srst_eff_i,
  input  logic [DATA_W-1:0] ram_q_i,
  output logic [DATA_W-1:0] data_o
);
  logic              sel_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sel_q <= 1'b0;
    else if (srst_eff_i) sel_q <= 1'b0;
    else                 sel_q <= en_eff_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= ARST_VAL;
    else if (srst_eff_i) hold_q <= SRST_VAL;
    else                 hold_q <= data_o;
  end

  assign data_o = sel_q ? ram_q_i : hold_q;

  p_arst_val_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> data_o == ARST_VAL);

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_eff_i && !srst_eff_i) |=> $stable(data_o));

  // covers R7 too: srst_eff is already qualified per mode
  p_srst_val_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_eff_i |=> data_o == SRST_VAL);
endmodule

// File: rtl/sync_rd_shell.sv
module sync_rd_shell
  import rdw_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 4,
  parameter logic [DATA_W-1:0] ARST_VAL = 8'hA5,
  parameter logic [DATA_W-1:0] SRST_VAL = 8'h3C,
  parameter prio_e             PRIO     = PRIO_SRST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              en_eff;
  logic              srst_eff;
  logic [DATA_W-1:0] ram_q;

  // native read strobe is always on
  rdw_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i    (clk_i),
    .rd_en_i  (1'b1),
    .rd_addr_i(rd_addr_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .q_o      (ram_q)
  );

  rdw_ctl #(.PRIO(PRIO)) u_ctl (
    .rd_en_i   (rd_en_i),
    .srst_i    (srst_i),
    .en_eff_o  (en_eff),
    .srst_eff_o(srst_eff)
  );

  rdw_hold #(.DATA_W(DATA_W), .ARST_VAL(ARST_VAL), .SRST_VAL(SRST_VAL)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_eff_i  (en_eff),
    .srst_eff_i(srst_eff),
    .ram_q_i   (ram_q),
    .data_o    (rd_data_o)
  );

  p_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !srst_i) |=> rd_data_o == ram_q);
endmodule

// File: tb/sync_rd_shell_tb.sv
`timescale 1ns/1ps
module sync_rd_shell_tb_top;
  import rdw_pkg::*;

  localparam logic [7:0] A_VAL = 8'hA5;
  localparam logic [7:0] S_VAL = 8'h3C;

  logic       clk_i = 1'b0;
  logic       rst_ni, srst_i, rd_en_i, wr_en_i;
  logic [3:0] rd_addr_i, wr_addr_i;
  logic [7:0] wr_data_i, out_a, out_b;

  logic [7:0] ref_mem [16];
  logic [7:0] ref_a, ref_b;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  sync_rd_shell #(.PRIO(PRIO_SRST)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i), .rd_en_i(rd_en_i),
    .rd_addr_i(rd_addr_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(out_a));

  sync_rd_shell #(.PRIO(PRIO_EN)) dut_alt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i), .rd_en_i(rd_en_i),
    .rd_addr_i(rd_addr_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(out_b));

  function automatic logic [7:0] ref_next(logic [7:0] cur, bit en_first,
                                          bit en, bit srst, logic [7:0] rd);
    if (srst && (!en_first || en)) return S_VAL;
    if (en) return rd;
    return cur;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // called at a falling edge; applies one rising edge and checks both ports
  task automatic cyc(bit en, bit srst, bit we, logic [3:0] wa, logic [7:0] wd,
                     logic [3:0] ra, string tag);
    logic [7:0] rd_old;
    string ta, tb;
    rd_en_i = en; srst_i = srst; wr_en_i = we;
    wr_addr_i = wa; wr_data_i = wd; rd_addr_i = ra;
    @(posedge clk_i);
    rd_old = ref_mem[ra];
    ref_a = ref_next(ref_a, 1'b0, en, srst, rd_old);
    ref_b = ref_next(ref_b, 1'b1, en, srst, rd_old);
    if (we) ref_mem[wa] = wd;
    @(negedge clk_i);
    ta = tag != "" ? tag : (srst ? "R6" : (en ? "R2" : "R3"));
    tb = tag != "" ? tag : (srst ? "R7" : (en ? "R2" : "R3"));
    chk(ta, out_a, ref_a);
    chk(tb, out_b, ref_b);
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_ni = 1'b0; srst_i = 0; rd_en_i = 0; wr_en_i = 0;
    rd_addr_i = 0; wr_addr_i = 0; wr_data_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R1", out_a, A_VAL);
    chk("R1", out_b, A_VAL);
    rst_ni = 1'b1;
    ref_a = A_VAL; ref_b = A_VAL;
    // fill memory with the enable low: output must hold the reset value
    for (int i = 0; i < 16; i++)
      cyc(0, 0, 1, 4'(i), 8'(i * 17 + 3), 4'(i), "R9");
    chk("R1", out_a, A_VAL);
    cyc(1, 0, 0, 0, 0, 4'd3, "R2");
    cyc(0, 0, 0, 0, 0, 4'd9, "R3");
    cyc(0, 0, 1, 4'd9, 8'h11, 4'd9, "R3");
    cyc(1, 0, 1, 4'd5, 8'h77, 4'd1, "R2");
    cyc(1, 0, 0, 0, 0, 4'd5, "R4");
    cyc(1, 0, 1, 4'd7, 8'hEE, 4'd7, "R5");
    cyc(1, 0, 0, 0, 0, 4'd7, "R4");
    // sync reset with enable low: modes diverge
    cyc(0, 1, 0, 0, 0, 4'd2, "");
    chk("R6", out_a, S_VAL);
    chk("R7", out_b, 8'hEE);
    cyc(1, 1, 0, 0, 0, 4'd2, "");
    chk("R7", out_b, S_VAL);
    cyc(0, 0, 0, 0, 0, 4'd4, "R9");
    cyc(0, 0, 1, 4'd4, 8'h42, 4'd4, "R9");
    // async reset mid-cycle with enable and sync reset high
    cyc(1, 0, 0, 0, 0, 4'd6, "R2");
    rd_en_i = 1; srst_i = 1; rst_ni = 1'b0;
    #2;
    chk("R8", out_a, A_VAL);
    chk("R8", out_b, A_VAL);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R8", out_a, A_VAL);
    chk("R8", out_b, A_VAL);
    rst_ni = 1'b1;
    ref_a = A_VAL; ref_b = A_VAL;
    cyc(0, 0, 0, 0, 0, 4'd6, "R9");
    chk("R1", out_b, A_VAL);
    for (int n = 0; n < 400; n++) begin
      bit en, sr, we;
      en = ($urandom % 10) < 7;
      sr = ($urandom % 10) < 2;
      we = ($urandom % 2) == 1;
      cyc(en, sr, we, 4'($urandom), 8'($urandom), 4'($urandom), "");
    end
    finish_run();
  end
endmodule